// File: doc/BRIEF.md
# Two-Stage Serial Bit-Rate Generator

This block derives the timing strobes for an asynchronous serial transmitter and receiver from one system clock. The first stage divides the clock by four times a selectable prescale factor. The factor is one of 1, 3, 4 or 13, so the set is not limited to powers of two. The second stage divides the result by a power of two from 1 to 128. The output of the second stage is a single-cycle strobe at sixteen times the bit rate, which a receiver uses to sample its line. A final divide by sixteen of that strobe gives a single-cycle strobe at the bit rate, which a transmitter uses to shift out its frame. The total division per bit is therefore 64 × prescale × 2^n.

An enable input gates the whole generator. While it is low, every counter is held cleared, so no strobe is produced and no counter toggles. Raising the enable starts a fresh count. Software is expected to set both select fields before it enables the block. What happens when a select changes in the middle of a count is left undefined.

Top module: `baud_gen2`

## Requirements
- R1: `pre_sel` picks the prescale factor P. The encodings are 2'b00 = 1, 2'b01 = 3, 2'b10 = 4 and 2'b11 = 13. The first stage divides the clock by 4·P.
- R2: `rate_sel` = n (3'b000 to 3'b111) divides the first-stage output by 2^n, that is by 1, 2, 4, 8, 16, 32, 64 or 128.
- R3: `sample_tick` is a one-cycle pulse with a period of exactly S = 4·P·2^n clocks. The first pulse after the enable rises appears once S−1 rising edges have been sampled with the enable high.
- R4: `bit_tick` pulses only in a cycle in which `sample_tick` also pulses, on every 16th one. The first `bit_tick` after enabling falls on the 16th `sample_tick`, so its period is 16·S.
- R5: While `enable` is low, neither strobe pulses and every count is held cleared. A later enable restarts with the full latency of R3, whatever count was reached before.
- R6: While `rst_n` is low, both strobes are low, even with `enable` high.
- R7: P = 1 and n = 0 give a bit period of 64 clocks (76,800 baud from 4.9152 MHz). P = 4 and n = 3 give 2,048 clocks (2,400 baud).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Generator enable; low holds all counters cleared |
| pre_sel | input | 2 | Prescale factor select |
| rate_sel | input | 3 | Power-of-two rate select |
| sample_tick | output | 1 | 16x oversampling strobe |
| bit_tick | output | 1 | 1x bit-rate strobe |

## Verification
The bit strobe and the sample strobe must fire in the same cycle, because every 16th sample pulse is also a bit pulse. The bench counts sample pulses from the enable up to the first bit pulse and expects exactly sixteen, and the checker requires a sample pulse in every bit-pulse cycle. The second case is a disable that lands while a count is in progress. The bench drops the enable for one cycle part-way through a period, then requires the next strobe to take the full fresh latency rather than the remainder of the old count.

// File: rtl/baud_gen2.sv
module baud_gen2 #(
  parameter int RATE_W   = 3,
  parameter int BASE_DIV = 4,
  parameter int OVS      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        pre_sel,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              sample_tick,
  output logic              bit_tick
);
  localparam int PRE_CW  = $clog2(BASE_DIV * 13);
  localparam int RATE_CW = (1 << RATE_W) - 1;
  localparam int OVS_CW  = $clog2(OVS);

  logic [PRE_CW-1:0]  pre_cnt, pre_top;
  logic [RATE_CW-1:0] rate_cnt;
  logic [RATE_CW:0]   rate_one, rate_lim;
  logic [OVS_CW-1:0]  ovs_cnt;
  logic               pre_tick;

  always_comb begin
    case (pre_sel)
      2'b00:   pre_top = PRE_CW'(BASE_DIV * 1 - 1);
      2'b01:   pre_top = PRE_CW'(BASE_DIV * 3 - 1);
      2'b10:   pre_top = PRE_CW'(BASE_DIV * 4 - 1);
      default: pre_top = PRE_CW'(BASE_DIV * 13 - 1);
    endcase
  end

  assign rate_one    = (RATE_CW + 1)'(1) << rate_sel;
  assign rate_lim    = rate_one - 1'b1;
  assign pre_tick    = enable && (pre_cnt == pre_top);
  assign sample_tick = pre_tick && ((rate_cnt & rate_lim[RATE_CW-1:0]) == rate_lim[RATE_CW-1:0]);
  assign bit_tick    = sample_tick && (ovs_cnt == OVS_CW'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      rate_cnt <= '0;
      ovs_cnt  <= '0;
    end else if (!enable) begin
      pre_cnt  <= '0;
      rate_cnt <= '0;
      ovs_cnt  <= '0;
    end else begin
      pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
      if (pre_tick)    rate_cnt <= rate_cnt + 1'b1;
      if (sample_tick) ovs_cnt  <= ovs_cnt + 1'b1;
    end
  end
endmodule

module baud_gen2_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic sample_tick,
  input logic bit_tick
);
  assert_bit_in_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);
  assert_quiet_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !sample_tick && !bit_tick);
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick);
  assert_restart_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |-> !sample_tick);
  always_comb begin
    if (!rst_n) assert_reset_low_R6: assert (!sample_tick && !bit_tick);
  end
endmodule

bind baud_gen2 baud_gen2_chk chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .sample_tick(sample_tick), .bit_tick(bit_tick)
);

// File: tb/baud_gen2_tb_top.sv
module baud_gen2_tb_top;
  logic clk = 0, rst_n = 0, enable = 0;
  logic [1:0] pre_sel = 0;
  logic [2:0] rate_sel = 0;
  logic sample_tick, bit_tick;
  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  baud_gen2 dut_i (.clk(clk), .rst_n(rst_n), .enable(enable), .pre_sel(pre_sel),
                   .rate_sel(rate_sel), .sample_tick(sample_tick), .bit_tick(bit_tick));

  localparam int NV = 6;
  localparam int VPRE  [NV] = '{0, 1, 2, 3, 0, 3};
  localparam int VRATE [NV] = '{0, 0, 3, 1, 7, 7};
  localparam int VPER  [NV] = '{4, 12, 128, 104, 512, 6656};

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog expired: actual %0d cycles expected < 190000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(input bit use_bit, input int limit, output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!(use_bit ? bit_tick : sample_tick) && n < limit);
  endtask

  task automatic restart(input int p, input int r);
    @(negedge clk);
    enable = 0; pre_sel = 2'(p); rate_sel = 3'(r);
    @(negedge clk);
    enable = 1;
  endtask

  initial begin
    int n, s, quiet;
    enable = 1;
    repeat (3) @(negedge clk);
    chk("R6 sample low in reset", int'(sample_tick), 0);
    chk("R6 bit low in reset", int'(bit_tick), 0);
    enable = 0;
    rst_n = 1;

    for (int v = 0; v < NV; v++) begin
      restart(VPRE[v], VRATE[v]);
      wait_tick(0, VPER[v] + 10, n);
      chk($sformatf("R1 R3 first latency vec%0d", v), n, VPER[v] - 1);
      wait_tick(0, VPER[v] + 10, n);
      chk($sformatf("R2 R3 period vec%0d", v), n, VPER[v]);
      wait_tick(0, VPER[v] + 10, n);
      chk($sformatf("R3 period again vec%0d", v), n, VPER[v]);
      if (VPER[v] <= 1024) begin
        restart(VPRE[v], VRATE[v]);
        n = 0; s = 0;
        do begin
          @(posedge clk); n++;
          @(negedge clk);
          if (sample_tick) s++;
        end while (!bit_tick && n < 20 * VPER[v]);
        chk($sformatf("R4 samples to first bit vec%0d", v), s, 16);
        chk($sformatf("R4 first bit latency vec%0d", v), n, 16 * VPER[v] - 1);
        wait_tick(1, 20 * VPER[v], n);
        chk($sformatf("R4 R7 bit period vec%0d", v), n, 16 * VPER[v]);
      end
    end

    restart(0, 0);
    wait_tick(1, 200, n);
    chk("R7 76800 baud bit period 64 (first)", n, 63);
    wait_tick(1, 200, n);
    chk("R7 76800 baud bit period 64", n, 64);

    @(negedge clk);
    enable = 0;
    quiet = 0;
    repeat (200) begin
      @(negedge clk);
      if (sample_tick || bit_tick) quiet++;
    end
    chk("R5 no strobes while disabled", quiet, 0);

    restart(0, 1);
    repeat (5) @(negedge clk);
    enable = 0;
    @(negedge clk);
    enable = 1;
    wait_tick(0, 50, n);
    chk("R5 restart after mid-count disable", n, 7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule